// File: doc/BRIEF.md
# Ballast fault supervisor

This block follows the operating mode of an electronic lamp ballast: supply lockout, filament warm-up, lamp strike, steady run and a latched fault. Each cycle it reads digital flags from external comparators. These flags report the supply against its turn-on and turn-off levels, the shutdown pin against its upper and lower levels, the lamp end-of-life window, and the half-bridge current sense. It also reads the phase of the low-side gate. From these it drives registered enables for the high-side, low-side and power-factor gate drivers, a reset for the warm-up timer and a stop for the oscillator.

The tolerance for over-current depends on the mode. During warm-up and strike, the block counts rising edges of the current-sense flag that arrive while the low-side phase is active, and it latches a fault when the count reaches a limit. During run, a single qualified edge is enough to latch the fault. The current-sense flag and the low-side phase pass through a two-flop synchronizer before edge detection. Once latched, a fault persists until the supply drops below its turn-off level or the shutdown pin is driven above its upper level. Either event returns the block to lockout.

Top module: `ballast_fault_supervisor`

## Requirements
- R1: After reset, `mode_o` is 0 (lockout), the three gate enables are low, and `tmr_rst_o` and `osc_stop_o` are high.
- R2: Mode codes are 0 lockout, 1 warm-up, 2 strike, 3 run, 4 fault. Lockout moves to warm-up one clock after `vcc_on_i` and `sd_lo_i` are both high, provided neither `vcc_off_i` nor `sd_hi_i` is high. In modes 1 to 3 all three gate enables are high, and `tmr_rst_o` and `osc_stop_o` are low.
- R3: `warm_done_i` moves warm-up to strike, and `strike_done_i` moves strike to run, each one clock later. These strobes have no effect in any other mode.
- R4: In any mode, `vcc_off_i` or `sd_hi_i` puts the block in lockout on the next clock.
- R5: In run, `eol_over_i` or `eol_under_i` enters fault on the next clock. Both are ignored in every other mode.
- R6: In fault, the three gate enables are low and `tmr_rst_o` and `osc_stop_o` are high, and these values hold for as long as the fault lasts.
- R7: Fault is left only to lockout, and only through `vcc_off_i` or `sd_hi_i`. The supply-good and shutdown-low flags alone do not restart the block from fault.
- R8: In warm-up and strike, qualified current-sense edges are counted. The count carries from warm-up into strike, and fault is entered once the count reaches OC_LIMIT (25 by default), at most 4 clocks after the edge that reaches it.
- R9: In run, a single qualified current-sense edge enters fault within 3 clocks.
- R10: A current-sense edge qualifies only when `lo_phase_i` is high. A flag held high for any length of time counts as one edge.
- R11: The edge count clears in lockout and on entry to run. It saturates at OC_LIMIT and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_off_i | input | 1 | Supply below turn-off level |
| sd_hi_i | input | 1 | Shutdown pin above upper level |
| sd_lo_i | input | 1 | Shutdown pin below lower level |
| eol_over_i | input | 1 | End-of-life sense above upper window limit |
| eol_under_i | input | 1 | End-of-life sense below lower window limit |
| oc_i | input | 1 | Current-sense over-threshold flag (asynchronous) |
| lo_phase_i | input | 1 | Low-side gate phase active (asynchronous) |
| warm_done_i | input | 1 | Warm-up time elapsed strobe |
| strike_done_i | input | 1 | Strike time elapsed strobe |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| pfc_en_o | output | 1 | Power-factor gate enable |
| tmr_rst_o | output | 1 | Warm-up timer reset |
| osc_stop_o | output | 1 | Oscillator disable |
| mode_o | output | 3 | Current mode code |

## Verification
The bench drives one edge short of the limit and then the edge at the limit. A counter that is off by one trips early or late. It splits the count across the move from warm-up to strike, so a design that clears the count on that move never trips. It holds the current-sense flag high for many cycles, which a level-sensitive counter would read as many edges, and it sends edges with the low-side phase inactive, which an unqualified counter would count. It restarts after a saturated count, which a design that fails to clear in lockout would trip at once. In run it checks that one edge trips the block while an unqualified one does not. It drives done strobes and window flags in modes where they must be ignored, and it offers supply-good to a latched fault, which a leaky fault state would leave.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

  typedef enum logic [2:0] {
    MD_OFF     = 3'd0,
    MD_PREHEAT = 3'd1,
    MD_IGNITE  = 3'd2,
    MD_RUN     = 3'd3,
    MD_FAULT   = 3'd4
  } mode_t;

  localparam int MODE_W = 3;

endpackage

// File: rtl/ballast_sync.sv
module ballast_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ballast_oc_counter.sv
module ballast_oc_counter #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_s,
  input  logic lo_s,
  input  logic count_en,
  input  logic clr,
  output logic hit,
  output logic at_limit
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          oc_d;
  logic [CW-1:0] cnt;

  // one strobe per rising edge of the flag, only inside the low-side phase
  assign hit      = oc_s & ~oc_d & lo_s;
  assign at_limit = (cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_d <= 1'b0;
      cnt  <= '0;
    end else begin
      oc_d <= oc_s;
      if (clr)
        cnt <= '0;
      else if (count_en && hit && (cnt != LIM))
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ballast_mode_fsm.sv
module ballast_mode_fsm
  import ballast_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  vcc_on,
  input  logic  vcc_off,
  input  logic  sd_hi,
  input  logic  sd_lo,
  input  logic  eol_over,
  input  logic  eol_under,
  input  logic  warm_done,
  input  logic  strike_done,
  input  logic  oc_hit,
  input  logic  oc_at_limit,
  output mode_t mode_q,
  output logic  count_en,
  output logic  count_clr,
  output logic  hs_en,
  output logic  ls_en,
  output logic  pfc_en,
  output logic  tmr_rst,
  output logic  osc_stop
);

  mode_t nxt;
  logic  enter_run;
  logic  active_nxt;

  always_comb begin
    nxt       = mode_q;
    enter_run = 1'b0;
    if (vcc_off || sd_hi) begin
      nxt = MD_OFF;
    end else begin
      case (mode_q)
        MD_OFF:     if (vcc_on && sd_lo) nxt = MD_PREHEAT;
        MD_PREHEAT: begin
          if (oc_at_limit)    nxt = MD_FAULT;
          else if (warm_done) nxt = MD_IGNITE;
        end
        MD_IGNITE: begin
          if (oc_at_limit) begin
            nxt = MD_FAULT;
          end else if (strike_done) begin
            nxt       = MD_RUN;
            enter_run = 1'b1;
          end
        end
        MD_RUN:     if (eol_over || eol_under || oc_hit) nxt = MD_FAULT;
        MD_FAULT:   nxt = MD_FAULT;
        default:    nxt = MD_OFF;
      endcase
    end
  end

  assign active_nxt = (nxt == MD_PREHEAT) || (nxt == MD_IGNITE) || (nxt == MD_RUN);
  assign count_en   = (mode_q == MD_PREHEAT) || (mode_q == MD_IGNITE);
  assign count_clr  = (mode_q == MD_OFF) || enter_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_OFF;
      hs_en    <= 1'b0;
      ls_en    <= 1'b0;
      pfc_en   <= 1'b0;
      tmr_rst  <= 1'b1;
      osc_stop <= 1'b1;
    end else begin
      mode_q   <= nxt;
      hs_en    <= active_nxt;
      ls_en    <= active_nxt;
      pfc_en   <= active_nxt;
      tmr_rst  <= ~active_nxt;
      osc_stop <= ~active_nxt;
    end
  end

endmodule

// File: rtl/ballast_fault_supervisor.sv
module ballast_fault_supervisor #(
  parameter int OC_LIMIT    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       sd_hi_i,
  input  logic       sd_lo_i,
  input  logic       eol_over_i,
  input  logic       eol_under_i,
  input  logic       oc_i,
  input  logic       lo_phase_i,
  input  logic       warm_done_i,
  input  logic       strike_done_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic       pfc_en_o,
  output logic       tmr_rst_o,
  output logic       osc_stop_o,
  output logic [2:0] mode_o
);

  logic [1:0]          async_in;
  logic [1:0]          sync_out;
  logic                oc_hit;
  logic                oc_at_limit;
  logic                count_en;
  logic                count_clr;
  ballast_pkg::mode_t  mode_q;

  assign async_in = {lo_phase_i, oc_i};

  ballast_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (sync_out)
  );

  ballast_oc_counter #(.LIMIT(OC_LIMIT)) i_cnt (
    .clk      (clk),
    .rst      (rst),
    .oc_s     (sync_out[0]),
    .lo_s     (sync_out[1]),
    .count_en (count_en),
    .clr      (count_clr),
    .hit      (oc_hit),
    .at_limit (oc_at_limit)
  );

  ballast_mode_fsm i_fsm (
    .clk         (clk),
    .rst         (rst),
    .vcc_on      (vcc_on_i),
    .vcc_off     (vcc_off_i),
    .sd_hi       (sd_hi_i),
    .sd_lo       (sd_lo_i),
    .eol_over    (eol_over_i),
    .eol_under   (eol_under_i),
    .warm_done   (warm_done_i),
    .strike_done (strike_done_i),
    .oc_hit      (oc_hit),
    .oc_at_limit (oc_at_limit),
    .mode_q      (mode_q),
    .count_en    (count_en),
    .count_clr   (count_clr),
    .hs_en       (hs_en_o),
    .ls_en       (ls_en_o),
    .pfc_en      (pfc_en_o),
    .tmr_rst     (tmr_rst_o),
    .osc_stop    (osc_stop_o)
  );

  assign mode_o = mode_q;

endmodule

// File: rtl/ballast_fault_supervisor_chk.sv
module ballast_fault_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       vcc_off_i,
  input logic       sd_hi_i,
  input logic       hs_en_o,
  input logic       ls_en_o,
  input logic       pfc_en_o,
  input logic       tmr_rst_o,
  input logic       osc_stop_o,
  input logic [2:0] mode_o
);

  localparam logic [2:0] M_OFF  = 3'(ballast_pkg::MD_OFF);
  localparam logic [2:0] M_WARM = 3'(ballast_pkg::MD_PREHEAT);
  localparam logic [2:0] M_STR  = 3'(ballast_pkg::MD_IGNITE);
  localparam logic [2:0] M_RUN  = 3'(ballast_pkg::MD_RUN);
  localparam logic [2:0] M_FLT  = 3'(ballast_pkg::MD_FAULT);

  p_fault_gates_low_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_FLT) |-> (!hs_en_o && !ls_en_o && !pfc_en_o));

  p_fault_clears_timers_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_FLT) |-> (tmr_rst_o && osc_stop_o));

  p_fault_exit_lockout_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_FLT) |=> (mode_o == M_FLT || mode_o == M_OFF));

  p_lockout_exit_warm_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_OFF) |=> (mode_o == M_OFF || mode_o == M_WARM));

  p_forced_lockout_r4: assert property (@(posedge clk) disable iff (rst)
    (vcc_off_i || sd_hi_i) |=> (mode_o == M_OFF));

  p_run_from_strike_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o != M_STR && mode_o != M_RUN) |=> (mode_o != M_RUN));

  p_active_gates_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_WARM || mode_o == M_STR || mode_o == M_RUN)
      |-> (hs_en_o && ls_en_o && pfc_en_o && !tmr_rst_o && !osc_stop_o));

endmodule

bind ballast_fault_supervisor ballast_fault_supervisor_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .vcc_off_i  (vcc_off_i),
  .sd_hi_i    (sd_hi_i),
  .hs_en_o    (hs_en_o),
  .ls_en_o    (ls_en_o),
  .pfc_en_o   (pfc_en_o),
  .tmr_rst_o  (tmr_rst_o),
  .osc_stop_o (osc_stop_o),
  .mode_o     (mode_o)
);

// File: tb/test_ballast_fault_supervisor.sv
`timescale 1ns/1ps
module test_ballast_fault_supervisor;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_on = 0, vcc_off = 0, sd_hi = 0, sd_lo = 0;
  logic eol_over = 0, eol_under = 0, oc = 0, lo_ph = 0;
  logic warm_done = 0, strike_done = 0;
  logic hs, ls, pfc, trst, ostop;
  logic [2:0] mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ballast_fault_supervisor i_ballast_fault_supervisor (
    .clk(clk), .rst(rst),
    .vcc_on_i(vcc_on), .vcc_off_i(vcc_off), .sd_hi_i(sd_hi), .sd_lo_i(sd_lo),
    .eol_over_i(eol_over), .eol_under_i(eol_under), .oc_i(oc), .lo_phase_i(lo_ph),
    .warm_done_i(warm_done), .strike_done_i(strike_done),
    .hs_en_o(hs), .ls_en_o(ls), .pfc_en_o(pfc), .tmr_rst_o(trst),
    .osc_stop_o(ostop), .mode_o(mode)
  );

  localparam logic [4:0] ACT = 5'b11100;
  localparam logic [4:0] OFF = 5'b00011;

  // [15:8] {vcc_on, vcc_off, sd_hi, sd_lo, eol_over, eol_under, warm_done, strike_done}
  // [7:5] expected mode, [4:0] expected {hs, ls, pfc, tmr_rst, osc_stop}
  localparam int NV = 21;
  localparam logic [15:0] VEC [NV] = '{
    {8'b1001_0000, 3'd1, ACT},  // R2 start warm-up
    {8'b1001_0010, 3'd2, ACT},  // R3 to strike
    {8'b1001_0001, 3'd3, ACT},  // R3 to run
    {8'b1001_0000, 3'd3, ACT},
    {8'b1001_1000, 3'd4, OFF},  // R5 over window
    {8'b1001_0000, 3'd4, OFF},  // R7 no restart from fault
    {8'b1010_0000, 3'd0, OFF},  // R7 shutdown exit
    {8'b1001_0000, 3'd1, ACT},
    {8'b1001_0010, 3'd2, ACT},
    {8'b1001_0001, 3'd3, ACT},
    {8'b1001_0100, 3'd4, OFF},  // R5 under window
    {8'b0101_0000, 3'd0, OFF},  // R7 supply exit
    {8'b0001_0000, 3'd0, OFF},  // R2 no supply, no start
    {8'b1001_0000, 3'd1, ACT},
    {8'b0101_0000, 3'd0, OFF},  // R4 undervoltage in warm-up
    {8'b1001_0000, 3'd1, ACT},
    {8'b1001_0001, 3'd1, ACT},  // R3 strike strobe ignored
    {8'b1001_1100, 3'd1, ACT},  // R5 window ignored
    {8'b1001_0010, 3'd2, ACT},
    {8'b1001_0010, 3'd2, ACT},  // R3 warm strobe ignored
    {8'b1010_0000, 3'd0, OFF}   // R4 shutdown in strike
  };

  task automatic check(input string req, input logic [2:0] exp_mode, input logic [4:0] exp_out);
    logic [7:0] act, exp;
    act = {mode, hs, ls, pfc, trst, ostop};
    exp = {exp_mode, exp_out};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual mode=%0d out=%b expected mode=%0d out=%b",
               req, act[7:5], act[4:0], exp[7:5], exp[4:0]);
    end
  endtask

  task automatic base();
    vcc_on = 1; vcc_off = 0; sd_hi = 0; sd_lo = 1;
    eol_over = 0; eol_under = 0; warm_done = 0; strike_done = 0;
  endtask

  task automatic pulse();
    oc = 1; repeat (3) @(negedge clk);
    oc = 0; repeat (3) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic restart();
    vcc_on = 0; vcc_off = 1; @(negedge clk);
    base(); @(negedge clk);
  endtask

  task automatic strobe_warm();
    warm_done = 1; @(negedge clk); warm_done = 0;
  endtask

  task automatic strobe_strike();
    strike_done = 1; @(negedge clk); strike_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'd0, OFF);
    rst = 0;
    @(negedge clk);
    check("R1 idle after reset", 3'd0, OFF);

    for (int v = 0; v < NV; v++) begin
      {vcc_on, vcc_off, sd_hi, sd_lo, eol_over, eol_under, warm_done, strike_done} = VEC[v][15:8];
      @(negedge clk);
      check($sformatf("table step %0d (R2/R3/R4/R5/R7)", v), VEC[v][7:5], VEC[v][4:0]);
    end

    // R8: limit reached in warm-up
    base(); lo_ph = 1; @(negedge clk);
    pulses(24);
    check("R8 one below limit stays warm-up", 3'd1, ACT);
    pulse();
    check("R8 limit trips fault", 3'd4, OFF);
    repeat (10) @(negedge clk);
    check("R6 fault held", 3'd4, OFF);

    // R11: count cleared through lockout
    restart();
    check("R11 restart warm-up", 3'd1, ACT);
    pulse();
    check("R11 count cleared in lockout", 3'd1, ACT);

    // R10: held flag counts once
    oc = 1; repeat (60) @(negedge clk); oc = 0; repeat (3) @(negedge clk);
    pulses(22);
    check("R10 held flag counted once", 3'd1, ACT);
    pulse();
    check("R10 limit after held flag", 3'd4, OFF);

    // R10: no qualification without low-side phase
    restart();
    lo_ph = 0;
    pulses(30);
    check("R10 unqualified edges ignored", 3'd1, ACT);

    // R8: count carries from warm-up into strike
    lo_ph = 1;
    pulses(20);
    strobe_warm(); @(negedge clk);
    check("R8 strike entered", 3'd2, ACT);
    pulses(4);
    check("R8 strike below limit", 3'd2, ACT);
    pulse();
    check("R8 limit trips in strike", 3'd4, OFF);

    // R9: single edge in run
    restart();
    strobe_warm(); strobe_strike(); @(negedge clk);
    check("R9 run entered", 3'd3, ACT);
    lo_ph = 0;
    pulse();
    check("R9 unqualified edge in run ignored", 3'd3, ACT);
    lo_ph = 1;
    pulse();
    check("R9 single edge trips run", 3'd4, OFF);

    // R1: reset from an active mode
    restart();
    rst = 1; @(negedge clk); @(negedge clk);
    check("R1 reset from warm-up", 3'd0, OFF);
    rst = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule